// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Master

This block is the host side of a 16-bit parallel bus to a six-channel converter. The converter's channels form three pairs, and the block runs the converter with the channel selection held in the converter's own configuration register. A command carries pair enables, per-pair range bits, two reference control bits and a word/byte flag. The block then performs one whole transaction. It writes an 8-bit configuration word on the upper half of the data bus, using a timed chip-select and write-strobe cycle. It pulses conversion start A. It waits for the busy line to rise and then fall. It then issues the read strobes needed to collect every selected channel.

Results leave the block as a one-cycle valid strobe, with a 16-bit value and a channel number. They always come out in ascending channel order. A one-cycle done pulse closes each transaction. The setup, strobe, hold, start-pulse, read-strobe and gap lengths are parameters in system clocks. A busy timeout aborts a conversion that never completes and raises a flag. A command that enables no pair completes at once, with no bus activity.

Top module: `sadc_bus_ctrl`

## Requirements
- R1: The configuration word on db_o[15:8] has the pair enables for pairs 3, 2 and 1 on bits 15, 14 and 13. The range bits for pairs 3, 2 and 1 are on bits 12, 11 and 10. The reference enable is on bit 9 and the buffer bypass on bit 8. db_o[7:0] is driven as zero.
- R2: During the configuration write, rd_no stays high and db_oe_o stays high. cs_no goes low T_SU cycles before wr_no falls. wr_no stays low for T_WL cycles. cs_no stays low with the data unchanged for T_HD cycles after wr_no rises.
- R3: After the write, conv_a_o is high for exactly T_CONV cycles, once per transaction. conv_b_o and conv_c_o are always low.
- R4: No read strobe starts before busy_i has been seen high and then low. Each read holds rd_no and cs_no low for T_RD cycles. Consecutive reads are separated by T_GAP cycles.
- R5: The number of read strobes is 2 per enabled pair in word mode (byte_mode_i=0) and 4 per enabled pair in byte mode.
- R6: Results come out in ascending channel order. Pair k (k = 1..3) is channels 2k-2 and 2k-1 on res_chan_o. Exactly two results are produced per enabled pair.
- R7: In word mode each result is db_i[15:0] from one read. In byte mode the byte on db_i[15:8] from the first read of a channel is the high byte, and the byte from the second read is the low byte.
- R8: If busy has not risen and fallen within TIMEOUT cycles after the start pulse ends, the transaction ends with no reads and timeout_o is raised. timeout_o is cleared when the next command is accepted.
- R9: cmd_ready_o is high only while idle. cmd_valid_i asserted while cmd_ready_o is low has no effect.
- R10: A command with no pair enabled produces no chip select, write, start or read activity, yields zero results, and ends with a done pulse.
- R11: done_o is a single-cycle pulse per transaction, and it comes after the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start a transaction with the settings below |
| cmd_ready_o | output | 1 | Idle; a command is accepted |
| pair_en_i | input | 3 | Pair enables, bit 0 = pair 1 |
| range_i | input | 3 | Per-pair range select, bit 0 = pair 1 |
| ref_en_i | input | 1 | Internal reference enable |
| buf_bypass_i | input | 1 | Reference buffer bypass |
| byte_mode_i | input | 1 | 1 = 8-bit reads on db_i[15:8] |
| cs_no | output | 1 | Chip select, active low |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| db_o | output | 16 | Data bus out |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 16 | Data bus in |
| conv_a_o | output | 1 | Conversion start A |
| conv_b_o | output | 1 | Conversion start B, held low |
| conv_c_o | output | 1 | Conversion start C, held low |
| busy_i | input | 1 | Converter busy |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 16 | Result value |
| res_chan_o | output | 3 | Result channel 0..5 |
| done_o | output | 1 | Transaction complete pulse |
| timeout_o | output | 1 | Last transaction timed out on busy |

## Verification
The embedded properties rely on the converter holding busy_i low for the whole read phase once it has fallen. This is what lets the read-after-busy check be stated against the live busy line. The bench's converter model raises busy on the start edge it observes, lowers it a fixed number of cycles later, and does not touch it again until the next start. In the stalled case it keeps busy high until the block has given up. The model answers each read strobe from its own channel list, which it decodes from the configuration word it captured. A wrong bit layout therefore shows up in the returned data as well as in the configuration check.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int NPAIRS = 3;
  localparam int NCH    = 2 * NPAIRS;

  typedef enum logic [3:0] {
    S_IDLE, S_WSU, S_WLO, S_WHD, S_CONV, S_BHI, S_BLO, S_RLO, S_RHI, S_DONE
  } state_t;

  typedef struct packed {
    logic [NPAIRS-1:0] pair_en;
    logic [NPAIRS-1:0] rng;
    logic              ref_en;
    logic              buf_byp;
    logic              byte_mode;
  } cfg_t;

  // upper pair enable lands on the top bit; layout decoded by the converter
  function automatic logic [7:0] cfg_word(cfg_t c);
    return {c.pair_en[2], c.pair_en[1], c.pair_en[0],
            c.rng[2], c.rng[1], c.rng[0], c.ref_en, c.buf_byp};
  endfunction
endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sadc_read_plan.sv
module sadc_read_plan #(
  parameter int NP  = 3,
  parameter int RIW = 4,
  parameter int CHW = 3
) (
  input  logic [NP-1:0]  en_i,
  input  logic           byte_i,
  input  logic [RIW-1:0] idx_i,
  output logic [RIW-1:0] n_reads_o,
  output logic [CHW-1:0] chan_o,
  output logic           hi_o,
  output logic           emit_o
);
  logic [RIW-1:0] n_p, ord, seen;
  logic [1:0]     sub;
  logic [CHW-1:0] sel;

  always_comb begin
    n_p = '0;
    for (int p = 0; p < NP; p++) n_p = n_p + RIW'(en_i[p]);
    n_reads_o = byte_i ? (n_p << 2) : (n_p << 1);

    ord = byte_i ? (idx_i >> 2) : (idx_i >> 1);
    sub = byte_i ? idx_i[1:0] : {1'b0, idx_i[0]};

    // ord-th enabled pair, lowest first
    sel  = '0;
    seen = '0;
    for (int p = 0; p < NP; p++) begin
      if (en_i[p]) begin
        if (seen == ord) sel = CHW'(p);
        seen = seen + 1'b1;
      end
    end

    chan_o = (sel << 1) | CHW'(byte_i ? sub[1] : sub[0]);
    hi_o   = byte_i & ~sub[0];
    emit_o = ~byte_i | sub[0];
  end
endmodule

// File: rtl/sadc_assembler.sv
module sadc_assembler #(
  parameter int DW  = 16,
  parameter int CHW = 3,
  parameter int NCH = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           cap_i,
  input  logic           byte_i,
  input  logic           hi_i,
  input  logic           emit_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [DW-1:0]  d_i,
  output logic           res_valid_o,
  output logic [DW-1:0]  res_data_o,
  output logic [CHW-1:0] res_chan_o
);
  localparam int HW = DW / 2;

  logic [HW-1:0]  hi_q;
  logic [CHW-1:0] last_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
      hi_q        <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (cap_i) begin
        if (byte_i && hi_i) hi_q <= d_i[DW-1 -: HW];
        if (emit_i) begin
          res_valid_o <= 1'b1;
          res_chan_o  <= chan_i;
          res_data_o  <= byte_i ? {hi_q, d_i[DW-1 -: HW]} : d_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      seen_q <= 1'b0;
    end else if (res_valid_o) begin
      last_q <= res_chan_o;
      seen_q <= 1'b1;
    end
  end

  p_ascend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && seen_q) |-> (res_chan_o > last_q));

  p_chan_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_chan_o < CHW'(NCH)));
endmodule

// File: rtl/sadc_bus_ctrl.sv
module sadc_bus_ctrl
  import sadc_pkg::*;
#(
  parameter int T_SU    = 2,
  parameter int T_WL    = 3,
  parameter int T_HD    = 2,
  parameter int T_CONV  = 2,
  parameter int T_RD    = 3,
  parameter int T_GAP   = 2,
  parameter int TIMEOUT = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic [2:0]  pair_en_i,
  input  logic [2:0]  range_i,
  input  logic        ref_en_i,
  input  logic        buf_bypass_i,
  input  logic        byte_mode_i,
  output logic        cs_no,
  output logic        wr_no,
  output logic        rd_no,
  output logic [15:0] db_o,
  output logic        db_oe_o,
  input  logic [15:0] db_i,
  output logic        conv_a_o,
  output logic        conv_b_o,
  output logic        conv_c_o,
  input  logic        busy_i,
  output logic        res_valid_o,
  output logic [15:0] res_data_o,
  output logic [2:0]  res_chan_o,
  output logic        done_o,
  output logic        timeout_o
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DW   = 16;
  localparam int CHW  = $clog2(NCH);
  localparam int RIW  = $clog2(4 * NPAIRS + 1);
  localparam int TMAX = imax(imax(imax(T_SU, T_WL), imax(T_HD, T_CONV)), imax(T_RD, T_GAP));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int TOW  = $clog2(TIMEOUT + 1);

  state_t         state_q, nxt;
  cfg_t           cfg_q;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic [TOW-1:0] tout_q;
  logic           tout_hit, waiting, timeout_q;
  logic [RIW-1:0] rd_idx_q, n_reads;
  logic [CHW-1:0] pl_chan;
  logic           pl_hi, pl_emit;
  logic           accept, cap;

  assign accept   = (state_q == S_IDLE) && cmd_valid_i;
  assign cap      = (state_q == S_RLO) && tmr_zero;
  assign waiting  = (state_q == S_BHI) || (state_q == S_BLO);
  assign tout_hit = (tout_q == TOW'(TIMEOUT - 1));

  sadc_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sadc_read_plan #(.NP(NPAIRS), .RIW(RIW), .CHW(CHW)) u_plan (
    .en_i      (cfg_q.pair_en),
    .byte_i    (cfg_q.byte_mode),
    .idx_i     (rd_idx_q),
    .n_reads_o (n_reads),
    .chan_o    (pl_chan),
    .hi_o      (pl_hi),
    .emit_o    (pl_emit)
  );

  sadc_assembler #(.DW(DW), .CHW(CHW), .NCH(NCH)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .cap_i       (cap),
    .byte_i      (cfg_q.byte_mode),
    .hi_i        (pl_hi),
    .emit_i      (pl_emit),
    .chan_i      (pl_chan),
    .d_i         (db_i),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .res_chan_o  (res_chan_o)
  );

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) begin
        if (pair_en_i == '0) nxt = S_DONE;
        else begin
          nxt = S_WSU; tmr_load = 1'b1; tmr_val = TW'(T_SU - 1);
        end
      end
      S_WSU: if (tmr_zero) begin
        nxt = S_WLO; tmr_load = 1'b1; tmr_val = TW'(T_WL - 1);
      end
      S_WLO: if (tmr_zero) begin
        nxt = S_WHD; tmr_load = 1'b1; tmr_val = TW'(T_HD - 1);
      end
      S_WHD: if (tmr_zero) begin
        nxt = S_CONV; tmr_load = 1'b1; tmr_val = TW'(T_CONV - 1);
      end
      S_CONV: if (tmr_zero) nxt = S_BHI;
      S_BHI: begin
        if (busy_i)        nxt = S_BLO;
        else if (tout_hit) nxt = S_DONE;
      end
      S_BLO: begin
        if (!busy_i) begin
          nxt = S_RLO; tmr_load = 1'b1; tmr_val = TW'(T_RD - 1);
        end else if (tout_hit) nxt = S_DONE;
      end
      S_RLO: if (tmr_zero) begin
        nxt = S_RHI; tmr_load = 1'b1; tmr_val = TW'(T_GAP - 1);
      end
      S_RHI: if (tmr_zero) begin
        if (rd_idx_q == n_reads) nxt = S_DONE;
        else begin
          nxt = S_RLO; tmr_load = 1'b1; tmr_val = TW'(T_RD - 1);
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cfg_q     <= '0;
      rd_idx_q  <= '0;
      tout_q    <= '0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (accept) begin
        cfg_q     <= '{pair_en: pair_en_i, rng: range_i, ref_en: ref_en_i,
                       buf_byp: buf_bypass_i, byte_mode: byte_mode_i};
        rd_idx_q  <= '0;
        timeout_q <= 1'b0;
      end else if (cap) begin
        rd_idx_q <= rd_idx_q + 1'b1;
      end
      tout_q <= waiting ? tout_q + 1'b1 : '0;
      if (waiting && tout_hit && nxt == S_DONE) timeout_q <= 1'b1;
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign db_oe_o     = (state_q == S_WSU) || (state_q == S_WLO) || (state_q == S_WHD);
  assign cs_no       = !(db_oe_o || (state_q == S_RLO));
  assign wr_no       = !(state_q == S_WLO);
  assign rd_no       = !(state_q == S_RLO);
  assign db_o        = {cfg_word(cfg_q), 8'h00};
  assign conv_a_o    = (state_q == S_CONV);
  assign conv_b_o    = 1'b0;
  assign conv_c_o    = 1'b0;
  assign done_o      = (state_q == S_DONE);
  assign timeout_o   = timeout_q;

  p_wr_framed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (!cs_no && rd_no && db_oe_o));

  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> ($stable(db_o) && !cs_no && db_oe_o));

  p_conv_quiet_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_a_o |-> (cs_no && rd_no && wr_no));

  p_rd_after_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> !busy_i);

  p_rd_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (rd_idx_q < n_reads));

  p_timeout_no_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> rd_no);

  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (cs_no && rd_no && wr_no && !conv_a_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o));
endmodule

// File: tb/sim_sadc_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sadc_bus_ctrl;
  localparam int T_SU = 2, T_WL = 3, T_HD = 2, T_CONV = 2, T_RD = 3, T_GAP = 2;
  localparam int TIMEOUT  = 64;
  localparam int BUSY_LEN = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [2:0]  pair_en_i = '0, range_i = '0;
  logic        ref_en_i = 1'b0, buf_bypass_i = 1'b0, byte_mode_i = 1'b0;
  logic        cs_no, wr_no, rd_no, db_oe_o;
  logic [15:0] db_o;
  logic [15:0] db_i;
  logic        conv_a_o, conv_b_o, conv_c_o;
  logic        busy_i;
  logic        res_valid_o;
  logic [15:0] res_data_o;
  logic [2:0]  res_chan_o;
  logic        done_o, timeout_o;

  always #2 clk = ~clk;

  sadc_bus_ctrl #(.T_SU(T_SU), .T_WL(T_WL), .T_HD(T_HD), .T_CONV(T_CONV),
                  .T_RD(T_RD), .T_GAP(T_GAP), .TIMEOUT(TIMEOUT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .pair_en_i(pair_en_i), .range_i(range_i), .ref_en_i(ref_en_i),
    .buf_bypass_i(buf_bypass_i), .byte_mode_i(byte_mode_i),
    .cs_no(cs_no), .wr_no(wr_no), .rd_no(rd_no), .db_o(db_o), .db_oe_o(db_oe_o),
    .db_i(db_i), .conv_a_o(conv_a_o), .conv_b_o(conv_b_o), .conv_c_o(conv_c_o),
    .busy_i(busy_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_chan_o(res_chan_o), .done_o(done_o), .timeout_o(timeout_o));

  int checks = 0, errors = 0;

  // written only by tasks
  logic stuck = 1'b0;
  logic cur_byte = 1'b0;

  // converter model and monitors, all at the falling edge
  int   conv_no = 0, conv_hi_tot = 0, bc_bad = 0;
  int   wr_pulses = 0, su_tot = 0, wl_tot = 0, hd_tot = 0, wframe_bad = 0, hold_bad = 0;
  int   rd_tot = 0, rdlow_tot = 0, rd_bad = 0, gap_tot = 0;
  int   res_n = 0, done_tot = 0, busy_cnt = 0, rd_k = 0, mcnt = 0, wphase = 0;
  int   res_ch [64];
  logic [15:0] res_d [64];
  int   mlist [6];
  logic [7:0]  cfg_cap = '0, cfg_lo = '0;
  logic [15:0] db_at_fall = '0;
  logic conv_q = 1'b0, wr_q = 1'b1, rd_q = 1'b1, rd_seen = 1'b0;

  function automatic logic [15:0] smp(int ch, int cn);
    return 16'(32'h3000 + ch * 257 + cn * 16);
  endfunction

  initial begin
    busy_i = 1'b0;
    db_i   = 16'h0000;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (conv_b_o || conv_c_o) bc_bad++;
      if (conv_a_o) conv_hi_tot++;
      if (conv_a_o && !conv_q) begin
        conv_no++;
        mcnt = 0;
        for (int p = 0; p < 3; p++)
          if (cfg_cap[5 + p]) begin mlist[mcnt] = 2 * p; mlist[mcnt + 1] = 2 * p + 1; mcnt += 2; end
        rd_k = 0;
        busy_i = 1'b1;
        busy_cnt = BUSY_LEN;
      end else if (busy_i && !stuck) begin
        busy_cnt--;
        if (busy_cnt == 0) busy_i = 1'b0;
      end
      // write cycle
      if (!wr_no && wr_q) db_at_fall = db_o;
      if (wr_no && !wr_q) begin
        wr_pulses++;
        cfg_cap = db_o[15:8];
        cfg_lo  = db_o[7:0];
        if (db_o != db_at_fall) hold_bad++;
      end
      if (!cs_no && db_oe_o) begin
        if (!rd_no) wframe_bad++;
        if (!wr_no) begin wphase = 2; wl_tot++; end
        else if (wphase <= 1) begin wphase = 1; su_tot++; end
        else begin wphase = 3; hd_tot++; end
      end else begin
        wphase = 0;
        if (!wr_no) wframe_bad++;
      end
      // reads
      if (!rd_no) begin
        rdlow_tot++;
        if (cs_no || busy_i) rd_bad++;
      end
      if (rd_no && rd_seen && !conv_a_o && !busy_i && cs_no && !done_o && !cmd_ready_o) gap_tot++;
      if (!rd_no && rd_q) begin
        rd_tot++;
        rd_seen = 1'b1;
        if (cur_byte) begin
          if (rd_k / 2 < mcnt)
            db_i = (rd_k % 2 == 0) ? {smp(mlist[rd_k / 2], conv_no)[15:8], 8'hEE}
                                   : {smp(mlist[rd_k / 2], conv_no)[7:0], 8'hEE};
        end else if (rd_k < mcnt) begin
          db_i = smp(mlist[rd_k], conv_no);
        end
        rd_k++;
      end
      if (done_o) begin done_tot++; rd_seen = 1'b0; end
      if (res_valid_o && res_n < 64) begin
        res_ch[res_n] = int'(res_chan_o);
        res_d[res_n]  = res_data_o;
        res_n++;
      end
    end
    conv_q = conv_a_o;
    wr_q   = wr_no;
    rd_q   = rd_no;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // full transaction with checks; poke drives a second command mid-run
  task automatic run_case(input logic [2:0] en, input logic [2:0] rng, input logic rf,
                          input logic bb, input logic bm, input logic stk, input logic poke);
    int c_conv, c_convhi, c_wr, c_su, c_wl, c_hd, c_rd, c_rdlow, c_res, c_done, c_gap;
    int npairs, exp_reads, exp_res, k, w;
    logic [7:0] exp_cfg;
    c_conv = conv_no; c_convhi = conv_hi_tot; c_wr = wr_pulses; c_su = su_tot;
    c_wl = wl_tot; c_hd = hd_tot; c_rd = rd_tot; c_rdlow = rdlow_tot;
    c_res = res_n; c_done = done_tot; c_gap = gap_tot;
    npairs = int'(en[0]) + int'(en[1]) + int'(en[2]);
    exp_reads = (en == 3'b000 || stk) ? 0 : npairs * (bm ? 4 : 2);
    exp_res   = (en == 3'b000 || stk) ? 0 : 2 * npairs;
    exp_cfg   = {en, rng, rf, bb};

    @(negedge clk);
    stuck = stk; cur_byte = bm;
    chk(cmd_ready_o == 1'b1, "R9 ready when idle", int'(cmd_ready_o), 1);
    pair_en_i = en; range_i = rng; ref_en_i = rf; buf_bypass_i = bb; byte_mode_i = bm;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    pair_en_i = ~en; byte_mode_i = ~bm;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(cmd_ready_o == 1'b0, "R9 busy refuses", int'(cmd_ready_o), 0);
      pair_en_i = 3'b111; cmd_valid_i = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid_i = 1'b0;
    end
    w = 0;
    while (done_tot == c_done && w < 4000) begin @(negedge clk); w++; end
    repeat (6) @(negedge clk);
    stuck = 1'b0;

    chk(done_tot - c_done == 1, "R11 one done pulse", done_tot - c_done, 1);
    chk(timeout_o == stk, "R8 timeout flag", int'(timeout_o), int'(stk));
    chk(rd_tot - c_rd == exp_reads, "R5 read strobe count", rd_tot - c_rd, exp_reads);
    chk(res_n - c_res == exp_res, "R6 result count", res_n - c_res, exp_res);
    chk(bc_bad == 0, "R3 start B/C low", bc_bad, 0);
    chk(rd_bad == 0, "R4 read framed after busy", rd_bad, 0);
    if (en == 3'b000) begin
      chk(wr_pulses - c_wr == 0, "R10 no write", wr_pulses - c_wr, 0);
      chk(conv_no - c_conv == 0, "R10 no start", conv_no - c_conv, 0);
    end else begin
      chk(cfg_cap == exp_cfg, "R1 config word", int'(cfg_cap), int'(exp_cfg));
      chk(cfg_lo == 8'h00, "R1 low byte zero", int'(cfg_lo), 0);
      chk(wr_pulses - c_wr == 1, "R2 one write", wr_pulses - c_wr, 1);
      chk(su_tot - c_su == T_SU, "R2 setup", su_tot - c_su, T_SU);
      chk(wl_tot - c_wl == T_WL, "R2 strobe width", wl_tot - c_wl, T_WL);
      chk(hd_tot - c_hd == T_HD, "R2 hold", hd_tot - c_hd, T_HD);
      chk(wframe_bad == 0 && hold_bad == 0, "R2 framing", wframe_bad + hold_bad, 0);
      chk(conv_hi_tot - c_convhi == T_CONV, "R3 start width", conv_hi_tot - c_convhi, T_CONV);
      chk(rdlow_tot - c_rdlow == exp_reads * T_RD, "R4 read width", rdlow_tot - c_rdlow, exp_reads * T_RD);
      if (exp_reads > 0)
        chk(gap_tot - c_gap == exp_reads * T_GAP, "R4 read gap", gap_tot - c_gap, exp_reads * T_GAP);
    end
    k = c_res;
    for (int p = 0; p < 3; p++) begin
      if (en[p] && !stk) begin
        for (int h = 0; h < 2; h++) begin
          if (k < res_n) begin
            chk(res_ch[k] == 2 * p + h, "R6 channel order", res_ch[k], 2 * p + h);
            chk(res_d[k] == smp(2 * p + h, conv_no),
                bm ? "R7 byte assembly" : "R7 word data", int'(res_d[k]), int'(smp(2 * p + h, conv_no)));
          end
          k++;
        end
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready_o == 1'b1, "R9 reset ready", int'(cmd_ready_o), 1);
    chk(cs_no && wr_no && rd_no, "R2 reset strobes high", int'({cs_no, wr_no, rd_no}), 7);
    chk(!conv_a_o && !done_o, "R3 reset start low", int'({conv_a_o, done_o}), 0);
    chk(!timeout_o && !res_valid_o, "R8 reset flags", int'({timeout_o, res_valid_o}), 0);
  endtask

  task automatic t_all_word();     run_case(3'b111, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_mid_byte();     run_case(3'b010, 3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_outer_poke();   run_case(3'b101, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); endtask
  task automatic t_all_byte();     run_case(3'b111, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_none();         run_case(3'b000, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_stuck();        run_case(3'b011, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_recover();      run_case(3'b001, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_top_pair_byte(); run_case(3'b100, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_all_word();
    t_mid_byte();
    t_outer_poke();
    t_all_byte();
    t_none();
    t_stuck();
    t_recover();
    t_top_pair_byte();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule